// File: doc/BRIEF.md
# Tagged-Byte Message Framer

This block turns a message made of 32-bit words into the stream of 10-bit tagged elements that a token-ring node keeps in its send buffer. Each element carries a 2-bit tag in bits 9:8 and a byte in bits 7:0. The tag marks each element as one of four kinds: header, data, trailer or token. A client first hands over a command with a destination node, a type byte and a word count. It then supplies the words one at a time through a valid/ready interface.

The framer holds a new command back until the send buffer reports empty. Once a command is accepted, the framer emits the following elements on a valid/ready element output, in this order:

1. A header naming its own node as source and the given node as destination.
2. The type byte.
3. Four data bytes for every word, least significant byte first.
4. A trailer.
5. A token, which hands the ring back to the other nodes.

A message that has started always runs to its end. Destination 15 is the broadcast address. The framer passes it through unchanged.

Top module: `tagged_msg_framer`

## Requirements
- R1: After reset, outValid and wordReady are low.
- R2: cmdReady is high only while no message is in progress and sendBufEmpty is high. A command offered while sendBufEmpty is low is not taken and produces no output.
- R3: The first element of a message has tag 10 (bits 9:8 = 2'b10). Its bits 7:4 hold nodeId and its bits 3:0 hold the destination, both sampled when the command is accepted.
- R4: The second element is the type byte with tag 00 (data).
- R5: Each word yields four elements with tag 00. They carry bits 7:0, then 15:8, then 23:16, then 31:24.
- R6: After the last data byte (or after the type byte when there are no words), the element 0x100 is emitted (tag 01, trailer). It is immediately followed by 0x300 (tag 11, token). After that, outValid stays low until the next command.
- R7: A command with wordCount zero yields exactly four elements: header, type, trailer and token. wordReady is never raised for such a command.
- R8: While outValid is high and outReady is low, outValid stays high and outElem keeps its value on the next cycle.
- R9: wordReady is high only while the framer waits for the next word of the current message, and never together with outValid. A word held valid during the header and type elements is taken exactly once.
- R10: Destination 15 (broadcast) appears unchanged as 0xF in bits 3:0 of the header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| nodeId | input | 4 | Number of this node, used as the header source |
| sendBufEmpty | input | 1 | High when the send buffer holds nothing |
| cmdValid | input | 1 | A message command is offered |
| cmdReady | output | 1 | The command is taken on this cycle when cmdValid is high |
| destId | input | 4 | Destination node of the offered command |
| typeByte | input | 8 | Type byte of the offered command |
| wordCount | input | CNT_W | Number of 32-bit words in the message |
| wordValid | input | 1 | A message word is offered |
| wordReady | output | 1 | The framer takes the offered word on this cycle |
| wordData | input | WORD_W | Message word |
| outValid | output | 1 | outElem holds an element |
| outReady | input | 1 | The downstream buffer takes the element |
| outElem | output | 10 | Tagged element: tag in bits 9:8, byte in bits 7:0 |

## Verification
The bench sends a message with no words. A framer that tested the count only after fetching a word would instead raise wordReady and insert four stray bytes between the type byte and the trailer. It stalls outReady on a repeating pattern in the middle of a broadcast message. A framer that advanced without a handshake would drop or repeat bytes, and one that let the element change while stalled would break the hold check. It offers a command while the send buffer reports non-empty, which catches a framer that starts early. It also keeps a word valid from the moment the command is issued, which exposes a framer that takes the word during the header and so duplicates or misorders it. Every message is compared element by element against an expected stream built from the byte order low to high, which catches swapped trailer and token tags as well as reversed byte order.

// File: rtl/framer_pkg.sv
`timescale 1ns/1ps
package framer_pkg;

  localparam logic [1:0] TAG_DATA  = 2'b00;
  localparam logic [1:0] TAG_TRAIL = 2'b01;
  localparam logic [1:0] TAG_HEAD  = 2'b10;
  localparam logic [1:0] TAG_TOKEN = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_TYPE,
    ST_WAIT,
    ST_BYTE,
    ST_TRAIL,
    ST_TOKEN
  } frameState_t;

  typedef enum logic [2:0] {
    SEL_HEAD,
    SEL_TYPE,
    SEL_DATA,
    SEL_TRAIL,
    SEL_TOKEN
  } elemSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadCmd;
    logic     loadWord;
    logic     nextByte;
    elemSel_t sel;
  } dpStrobe_t;

endpackage

// File: rtl/framer_dpath.sv
`timescale 1ns/1ps
module framer_dpath
  import framer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [3:0]        nodeId,
  input  logic [3:0]        destId,
  input  logic [7:0]        typeByte,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic [WORD_W-1:0] wordData,
  output logic              countZero,
  output logic              lastByte,
  output logic              lastWord,
  output logic [9:0]        outElem
);

  localparam int NBYTES = WORD_W / 8;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBYTES - 1);

  logic [7:0]        headReg;
  logic [7:0]        typeReg;
  logic [CNT_W-1:0]  remain;
  logic [WORD_W-1:0] wordReg;
  logic [WORD_W-1:0] rotWord;
  logic [IDX_W-1:0]  byteIdx;

  // rotate right by one byte so the next byte sits in the low lane
  for (genvar g = 0; g < NBYTES; g++) begin : g_rot
    assign rotWord[g*8 +: 8] = wordReg[((g + 1) % NBYTES)*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headReg <= '0;
      typeReg <= '0;
      remain  <= '0;
      wordReg <= '0;
      byteIdx <= '0;
    end else begin
      if (strobe.loadCmd) begin
        headReg <= {nodeId, destId};
        typeReg <= typeByte;
        remain  <= wordCount;
      end
      if (strobe.loadWord) begin
        wordReg <= wordData;
        byteIdx <= '0;
      end else if (strobe.nextByte) begin
        wordReg <= rotWord;
        byteIdx <= byteIdx + IDX_W'(1);
        if (byteIdx == IDX_LAST) remain <= remain - CNT_W'(1);
      end
    end
  end

  assign countZero = (remain == '0);
  assign lastWord  = (remain == CNT_W'(1));
  assign lastByte  = (byteIdx == IDX_LAST);

  always_comb begin
    unique case (strobe.sel)
      SEL_HEAD:  outElem = {TAG_HEAD, headReg};
      SEL_TYPE:  outElem = {TAG_DATA, typeReg};
      SEL_DATA:  outElem = {TAG_DATA, wordReg[7:0]};
      SEL_TRAIL: outElem = {TAG_TRAIL, 8'h00};
      SEL_TOKEN: outElem = {TAG_TOKEN, 8'h00};
      default:   outElem = {TAG_DATA, 8'h00};
    endcase
  end

endmodule

// File: rtl/framer_ctrl.sv
`timescale 1ns/1ps
module framer_ctrl
  import framer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sendBufEmpty,
  input  logic      cmdValid,
  input  logic      wordValid,
  input  logic      outReady,
  input  logic      countZero,
  input  logic      lastByte,
  input  logic      lastWord,
  output logic      cmdReady,
  output logic      wordReady,
  output logic      outValid,
  output dpStrobe_t strobe
);

  frameState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState       = state;
    cmdReady        = 1'b0;
    wordReady       = 1'b0;
    outValid        = 1'b0;
    strobe.loadCmd  = 1'b0;
    strobe.loadWord = 1'b0;
    strobe.nextByte = 1'b0;
    strobe.sel      = SEL_HEAD;
    unique case (state)
      ST_IDLE: begin
        cmdReady = sendBufEmpty;
        if (cmdValid && sendBufEmpty) begin
          strobe.loadCmd = 1'b1;
          nextState      = ST_HEAD;
        end
      end
      ST_HEAD: begin
        outValid   = 1'b1;
        strobe.sel = SEL_HEAD;
        if (outReady) nextState = ST_TYPE;
      end
      ST_TYPE: begin
        outValid   = 1'b1;
        strobe.sel = SEL_TYPE;
        if (outReady) nextState = countZero ? ST_TRAIL : ST_WAIT;
      end
      ST_WAIT: begin
        wordReady = 1'b1;
        if (wordValid) begin
          strobe.loadWord = 1'b1;
          nextState       = ST_BYTE;
        end
      end
      ST_BYTE: begin
        outValid   = 1'b1;
        strobe.sel = SEL_DATA;
        if (outReady) begin
          strobe.nextByte = 1'b1;
          if (lastByte) nextState = lastWord ? ST_TRAIL : ST_WAIT;
        end
      end
      ST_TRAIL: begin
        outValid   = 1'b1;
        strobe.sel = SEL_TRAIL;
        if (outReady) nextState = ST_TOKEN;
      end
      ST_TOKEN: begin
        outValid   = 1'b1;
        strobe.sel = SEL_TOKEN;
        if (outReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/tagged_msg_framer.sv
`timescale 1ns/1ps
module tagged_msg_framer
  import framer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        nodeId,
  input  logic              sendBufEmpty,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [3:0]        destId,
  input  logic [7:0]        typeByte,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic              wordValid,
  output logic              wordReady,
  input  logic [WORD_W-1:0] wordData,
  output logic              outValid,
  input  logic              outReady,
  output logic [9:0]        outElem
);

  dpStrobe_t strobe;
  logic      countZero;
  logic      lastByte;
  logic      lastWord;

  framer_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sendBufEmpty (sendBufEmpty),
    .cmdValid     (cmdValid),
    .wordValid    (wordValid),
    .outReady     (outReady),
    .countZero    (countZero),
    .lastByte     (lastByte),
    .lastWord     (lastWord),
    .cmdReady     (cmdReady),
    .wordReady    (wordReady),
    .outValid     (outValid),
    .strobe       (strobe)
  );

  framer_dpath #(
    .CNT_W  (CNT_W),
    .WORD_W (WORD_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .nodeId    (nodeId),
    .destId    (destId),
    .typeByte  (typeByte),
    .wordCount (wordCount),
    .wordData  (wordData),
    .countZero (countZero),
    .lastByte  (lastByte),
    .lastWord  (lastWord),
    .outElem   (outElem)
  );

endmodule

// File: rtl/framer_checker.sv
`timescale 1ns/1ps
module framer_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] nodeId,
  input logic [3:0] destId,
  input logic       sendBufEmpty,
  input logic       cmdValid,
  input logic       cmdReady,
  input logic       wordValid,
  input logic       wordReady,
  input logic       outValid,
  input logic       outReady,
  input logic [9:0] outElem
);

  p_cmd_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (sendBufEmpty && !outValid && !wordReady));

  p_header_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> (outValid && outElem[9:8] == 2'b10 &&
      outElem[7:4] == $past(nodeId) && outElem[3:0] == $past(destId)));

  p_token_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outElem == 10'h100) |=> (outValid && outElem == 10'h300));

  p_idle_after_token_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outElem == 10'h300) |=> !outValid);

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outElem)));

  p_word_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> !outValid);

  p_word_wait_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wordReady && !wordValid) |=> wordReady);

endmodule

bind tagged_msg_framer framer_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .nodeId       (nodeId),
  .destId       (destId),
  .sendBufEmpty (sendBufEmpty),
  .cmdValid     (cmdValid),
  .cmdReady     (cmdReady),
  .wordValid    (wordValid),
  .wordReady    (wordReady),
  .outValid     (outValid),
  .outReady     (outReady),
  .outElem      (outElem)
);

// File: tb/tb_tagged_msg_framer.sv
`timescale 1ns/1ps
module tb_tagged_msg_framer;

  localparam int CNT_W  = 8;
  localparam int WORD_W = 32;
  localparam logic [3:0] MY_NODE = 4'd6;

  logic              clk = 1'b0;
  logic              rstN;
  logic [3:0]        nodeId;
  logic              sendBufEmpty;
  logic              cmdValid;
  logic              cmdReady;
  logic [3:0]        destId;
  logic [7:0]        typeByte;
  logic [CNT_W-1:0]  wordCount;
  logic              wordValid;
  logic              wordReady;
  logic [WORD_W-1:0] wordData;
  logic              outValid;
  logic              outReady;
  logic [9:0]        outElem;

  always #2.5 clk = ~clk;

  tagged_msg_framer #(.CNT_W(CNT_W), .WORD_W(WORD_W)) dut (
    .clk(clk), .rstN(rstN), .nodeId(nodeId), .sendBufEmpty(sendBufEmpty),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .destId(destId),
    .typeByte(typeByte), .wordCount(wordCount), .wordValid(wordValid),
    .wordReady(wordReady), .wordData(wordData), .outValid(outValid),
    .outReady(outReady), .outElem(outElem)
  );

  int checks = 0;
  int fails  = 0;
  int readyMode = 0;
  int cyc = 0;

  logic [9:0]  cap [0:255];
  int          capN = 0;
  logic        wrSeen = 1'b0;
  logic        overlapSeen = 1'b0;
  logic        holdPend = 1'b0;
  logic [9:0]  holdElem = '0;
  logic [31:0] wbuf [0:15];

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // downstream ready pattern
  always begin
    @(posedge clk);
    #1;
    cyc++;
    if (readyMode == 0) outReady = 1'b1;
    else                outReady = ((cyc % 3) != 0);
  end

  // element collector and stall-hold observer, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (holdPend) begin
        // R8: stalled element must persist
        check(outValid && outElem == holdElem, "R8", int'(outElem), int'(holdElem));
      end
      holdPend = outValid && !outReady;
      holdElem = outElem;
      if (outValid && outReady && capN < 256) begin
        cap[capN] = outElem;
        capN++;
      end
      if (wordReady) wrSeen = 1'b1;
      if (wordReady && outValid) overlapSeen = 1'b1;
    end
  end

  task automatic runMsg(input logic [3:0] dst, input logic [7:0] typ,
                        input int n, input logic early);
    logic [9:0] exp [0:255];
    int expN;
    int waitCnt;
    capN   = 0;
    wrSeen = 1'b0;
    expN = 0;
    exp[expN++] = {2'b10, MY_NODE, dst};
    exp[expN++] = {2'b00, typ};
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 4; b++)
        exp[expN++] = {2'b00, wbuf[i][b*8 +: 8]};
    exp[expN++] = 10'h100;
    exp[expN++] = 10'h300;

    @(posedge clk); #1;
    destId    = dst;
    typeByte  = typ;
    wordCount = CNT_W'(n);
    cmdValid  = 1'b1;
    if (early && n > 0) begin
      wordValid = 1'b1;
      wordData  = wbuf[0];
    end
    do @(negedge clk); while (!cmdReady);
    @(posedge clk); #1;
    cmdValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      wordValid = 1'b1;
      wordData  = wbuf[i];
      do @(negedge clk); while (!wordReady);
      @(posedge clk); #1;
      wordValid = 1'b0;
    end
    waitCnt = 0;
    while (capN < expN && waitCnt < 2000) begin
      @(negedge clk);
      waitCnt++;
    end
    repeat (6) @(negedge clk);
    check(capN == expN, "R6 element count", capN, expN);
    for (int k = 0; k < expN; k++) begin
      string req;
      if (k == 0)             req = (dst == 4'hF) ? "R10 header" : "R3 header";
      else if (k == 1)        req = "R4 type";
      else if (k >= expN - 2) req = "R6 trailer/token";
      else                    req = "R5 data byte";
      check(cap[k] == exp[k], req, int'(cap[k]), int'(exp[k]));
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    check(wordReady == 1'b0, "R1 wordReady", int'(wordReady), 0);
    check(cmdReady == 1'b1, "R2 idle ready", int'(cmdReady), 1);
  endtask

  task automatic testBasic();
    wbuf[0] = 32'h44332211;
    wbuf[1] = 32'hDDCCBBAA;
    readyMode = 0;
    runMsg(4'd3, 8'h5A, 2, 1'b0);
  endtask

  task automatic testZeroWords();
    readyMode = 0;
    runMsg(4'd8, 8'h00, 0, 1'b0);
    check(wrSeen == 1'b0, "R7 no word request", int'(wrSeen), 0);
    check(capN == 4, "R7 four elements", capN, 4);
  endtask

  task automatic testBroadcastStall();
    wbuf[0] = 32'h0A0B0C0D;
    wbuf[1] = 32'h80FF7F01;
    wbuf[2] = 32'h12345678;
    readyMode = 1;
    runMsg(4'hF, 8'hC3, 3, 1'b0);
    readyMode = 0;
  endtask

  task automatic testBufBusy();
    logic bad;
    capN = 0;
    bad  = 1'b0;
    @(posedge clk); #1;
    sendBufEmpty = 1'b0;
    destId    = 4'd1;
    typeByte  = 8'h77;
    wordCount = '0;
    cmdValid  = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (cmdReady || outValid) bad = 1'b1;
    end
    check(bad == 1'b0, "R2 blocked while buffer busy", int'(bad), 0);
    check(capN == 0, "R2 no output while busy", capN, 0);
    @(posedge clk); #1;
    sendBufEmpty = 1'b1;
    do @(negedge clk); while (!cmdReady);
    @(posedge clk); #1;
    cmdValid = 1'b0;
    repeat (12) @(negedge clk);
    check(capN == 4, "R2 starts after empty", capN, 4);
    check(cap[0] == {2'b10, MY_NODE, 4'd1}, "R3 header after wait", int'(cap[0]),
          int'({2'b10, MY_NODE, 4'd1}));
  endtask

  task automatic testEarlyWord();
    wbuf[0] = 32'hCAFEF00D;
    wbuf[1] = 32'h00000001;
    readyMode = 1;
    runMsg(4'd2, 8'h11, 2, 1'b1);
    readyMode = 0;
    check(overlapSeen == 1'b0, "R9 wordReady exclusive", int'(overlapSeen), 0);
  endtask

  // watchdog
  always begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    nodeId = MY_NODE;
    sendBufEmpty = 1'b1;
    cmdValid = 1'b0;
    destId = '0;
    typeByte = '0;
    wordCount = '0;
    wordValid = 1'b0;
    wordData = '0;
    outReady = 1'b1;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testBasic();
    testZeroWords();
    testBroadcastStall();
    testBufBusy();
    testEarlyWord();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule